// File: doc/BRIEF.md
# Debug Breakpoint Trigger Comparator

This block watches every cycle of the processor's local bus together with the current program counter, and raises a trigger when a programmed combination of conditions is met. Three kinds of condition exist. A data condition compares the bus data against a reference value, over a chosen word or byte lane, with an optional inversion. An address condition tests the bus address against a low bound, an inclusive low-to-high window, or the area outside that window. A program-counter condition tests the PC against a base value, with a mask that excludes bits from the compare, and can fire either inside or outside the masked region.

The programming arrives on plain input ports: one 16-bit control slice per trigger level, plus a shared reference data value, low and high address bounds, and the PC base and mask. Each level has its own trigger output. In a level, every condition group that has at least one enable bit set must match. The result is captured only on a valid bus cycle and appears one clock later. Halting the processor and the serial debug link belong to other blocks.

Top module: `bp_trigger_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every trigger output is low.
- R2: A trigger output is high in the cycle after a bus cycle with `bus_valid_i` high in which its level matched. After any cycle with `bus_valid_i` low, every trigger output is low.
- R3: A level whose data enables (control bits 12:6), address enables (bits 4:2) and PC enable (bit 1) are all clear never triggers, whatever the invert bits hold.
- R4: Control bit 12 enables a compare of all 32 data bits. It is evaluated only on a longword access (`bus_size_i` = 2'b10).
- R5: Control bit 10 compares data bits 31:16 and bit 11 compares bits 15:0. A word access (`bus_size_i` = 2'b01) drives bits 31:16 when address bit 1 is 0 and bits 15:0 when it is 1. A longword access drives both.
- R6: Control bits 6, 7, 8 and 9 compare data bytes 31:24, 23:16, 15:8 and 7:0. A byte access (`bus_size_i` = 2'b00) at address bits 1:0 = 0, 1, 2, 3 drives byte 31:24, 23:16, 15:8, 7:0 respectively. Word and longword accesses drive the bytes they contain. An enabled lane that the access does not fully drive is ignored.
- R7: Control bit 5 inverts every lane compare, so a lane matches when its bytes differ from the reference. The data group matches when any enabled, driven lane matches. An enabled data group with no driven lane does not match.
- R8: Control bit 2 matches an address equal to the low bound. Bit 3 matches an address from the low bound to the high bound inclusive. Bit 4 matches an address outside that window. When several of these bits are set, the address group matches if any of them does.
- R9: Control bit 1 enables the PC group. A PC mask bit of 1 removes that bit from the compare. With control bit 0 clear, the group matches when (PC xor base) and not mask is zero. With bit 0 set, it matches when that value is non-zero.
- R10: Inside a level, the trigger requires every enabled group (data, address, PC) to match at once.
- R11: Level 0 takes control bits 12:0 and drives `trig_o[0]`. Level 1 takes the same layout in bits 28:16 and drives `trig_o[1]`. Both levels use the shared reference values. Size code 2'b11 drives no data lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_i | input | 16*LEVELS | Per-level control slices, 16 bits per level |
| data_ref_i | input | 32 | Reference value for data compares |
| addr_lo_i | input | ADDR_W | Low address bound |
| addr_hi_i | input | ADDR_W | High address bound |
| pc_base_i | input | PC_W | PC region base |
| pc_mask_i | input | PC_W | PC region mask, 1 = ignore bit |
| bus_valid_i | input | 1 | Bus cycle valid strobe |
| bus_addr_i | input | ADDR_W | Bus address |
| bus_size_i | input | 2 | Access size: 00 byte, 01 word, 10 longword, 11 none |
| bus_data_i | input | 32 | Bus data |
| pc_i | input | PC_W | Program counter |
| trig_o | output | LEVELS | Registered trigger, one per level |

## Verification
The assertions assume that `bus_size_i` and the low address bits are meaningful in the same cycle as `bus_valid_i`, and that the control and reference inputs are steady for the whole cycle in which they are sampled. The bench changes every input only on the falling edge, so each sampled bus cycle sees a complete and consistent set of values. It drives all four size codes, with low address bits that are always legal for the chosen size. The window sweeps keep the low bound at or below the high bound, which is the only case the window assertions rely on.

// File: rtl/bp_pkg.sv
package bp_pkg;

    localparam int DATA_W    = 32;
    localparam int NUM_BYTES = DATA_W / 8;
    localparam int NUM_LANES = 7;
    localparam int SLICE_W   = 16;
    localparam int USED_W    = 13;

    // Bus access size codes
    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10,
        SZ_NONE = 2'b11
    } bus_size_e;

    // One level of control, MSB first: bit 12 down to bit 0
    typedef struct packed {
        logic en_long;    // 12
        logic en_wlo;     // 11
        logic en_whi;     // 10
        logic en_b0;      // 9  bits 7:0
        logic en_b1;      // 8  bits 15:8
        logic en_b2;      // 7  bits 23:16
        logic en_b3;      // 6  bits 31:24
        logic data_inv;   // 5
        logic addr_out;   // 4
        logic addr_win;   // 3
        logic addr_eq;    // 2
        logic pc_en;      // 1
        logic pc_inv;     // 0
    } lvl_ctrl_t;

    // Lane vector order, index 6 down to 0, mirrors control bits 12:6
    typedef struct packed {
        logic lng;
        logic wlo;
        logic whi;
        logic b0;
        logic b1;
        logic b2;
        logic b3;
    } lane_vec_t;

endpackage

// File: rtl/bp_lane_decode.sv
module bp_lane_decode
    import bp_pkg::*;
(
    input  logic [1:0] size_i,
    input  logic [1:0] addr_lsb_i,
    output lane_vec_t  cov_o
);

    logic [NUM_BYTES-1:0] drv_d;   // bit 3 = bits 31:24

    always_comb begin
        drv_d = '0;
        unique case (bus_size_e'(size_i))
            SZ_BYTE: drv_d = 4'b1000 >> addr_lsb_i;
            SZ_WORD: drv_d = addr_lsb_i[1] ? 4'b0011 : 4'b1100;
            SZ_LONG: drv_d = 4'b1111;
            default: drv_d = '0;
        endcase
    end

    always_comb begin
        cov_o.lng = &drv_d;
        cov_o.whi = drv_d[3] & drv_d[2];
        cov_o.wlo = drv_d[1] & drv_d[0];
        cov_o.b3  = drv_d[3];
        cov_o.b2  = drv_d[2];
        cov_o.b1  = drv_d[1];
        cov_o.b0  = drv_d[0];
    end

endmodule

// File: rtl/bp_data_cmp.sv
module bp_data_cmp
    import bp_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    input  logic [DATA_W-1:0] ref_i,
    input  lane_vec_t         cov_i,
    input  lvl_ctrl_t         ctrl_i,
    output logic              en_o,
    output logic              hit_o
);

    logic [NUM_BYTES-1:0] byte_eq_d;
    lane_vec_t            lane_eq_d;
    lane_vec_t            lane_en_d;
    lane_vec_t            lane_res_d;

    for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
        assign byte_eq_d[b] = (data_i[b*8 +: 8] == ref_i[b*8 +: 8]);
    end

    always_comb begin
        lane_eq_d.lng = &byte_eq_d;
        lane_eq_d.whi = byte_eq_d[3] & byte_eq_d[2];
        lane_eq_d.wlo = byte_eq_d[1] & byte_eq_d[0];
        lane_eq_d.b3  = byte_eq_d[3];
        lane_eq_d.b2  = byte_eq_d[2];
        lane_eq_d.b1  = byte_eq_d[1];
        lane_eq_d.b0  = byte_eq_d[0];

        lane_en_d  = lane_vec_t'(ctrl_i[USED_W-1 -: NUM_LANES]);
        lane_res_d = lane_vec_t'(lane_en_d & cov_i &
                                 (lane_eq_d ^ {NUM_LANES{ctrl_i.data_inv}}));
        en_o  = |lane_en_d;
        hit_o = |lane_res_d;
    end

endmodule

// File: rtl/bp_addr_cmp.sv
module bp_addr_cmp
    import bp_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ADDR_W-1:0] lo_i,
    input  logic [ADDR_W-1:0] hi_i,
    input  lvl_ctrl_t         ctrl_i,
    output logic              en_o,
    output logic              hit_o
);

    logic eq_d;
    logic in_win_d;

    always_comb begin
        eq_d     = (addr_i == lo_i);
        in_win_d = (addr_i >= lo_i) && (addr_i <= hi_i);
        en_o     = ctrl_i.addr_eq | ctrl_i.addr_win | ctrl_i.addr_out;
        hit_o    = (ctrl_i.addr_eq  &  eq_d)
                 | (ctrl_i.addr_win &  in_win_d)
                 | (ctrl_i.addr_out & ~in_win_d);
    end

endmodule

// File: rtl/bp_pc_cmp.sv
module bp_pc_cmp
    import bp_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic [PC_W-1:0] pc_i,
    input  logic [PC_W-1:0] base_i,
    input  logic [PC_W-1:0] mask_i,
    input  lvl_ctrl_t       ctrl_i,
    output logic            en_o,
    output logic            hit_o
);

    logic inside_d;

    always_comb begin
        inside_d = (((pc_i ^ base_i) & ~mask_i) == '0);
        en_o     = ctrl_i.pc_en;
        hit_o    = inside_d ^ ctrl_i.pc_inv;
    end

endmodule

// File: rtl/bp_trigger_unit.sv
module bp_trigger_unit
    import bp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int PC_W   = 32,
    parameter int LEVELS = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [SLICE_W*LEVELS-1:0] ctrl_i,
    input  logic [DATA_W-1:0]         data_ref_i,
    input  logic [ADDR_W-1:0]         addr_lo_i,
    input  logic [ADDR_W-1:0]         addr_hi_i,
    input  logic [PC_W-1:0]           pc_base_i,
    input  logic [PC_W-1:0]           pc_mask_i,
    input  logic                      bus_valid_i,
    input  logic [ADDR_W-1:0]         bus_addr_i,
    input  logic [1:0]                bus_size_i,
    input  logic [DATA_W-1:0]         bus_data_i,
    input  logic [PC_W-1:0]           pc_i,
    output logic [LEVELS-1:0]         trig_o
);

    typedef struct packed {
        logic [LEVELS-1:0] trig;
    } state_t;

    state_t    st_d, st_q;
    lane_vec_t cov_w;

    logic [LEVELS-1:0] d_en, d_hit, a_en, a_hit, p_en, p_hit, lvl_match;

    bp_lane_decode u_lanes (
        .size_i     (bus_size_i),
        .addr_lsb_i (bus_addr_i[1:0]),
        .cov_o      (cov_w)
    );

    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        lvl_ctrl_t c_w;
        logic [SLICE_W-USED_W-1:0] unused_spare;

        assign c_w          = lvl_ctrl_t'(ctrl_i[l*SLICE_W +: USED_W]);
        assign unused_spare = ctrl_i[l*SLICE_W+USED_W +: SLICE_W-USED_W];

        bp_data_cmp u_data (
            .data_i (bus_data_i),
            .ref_i  (data_ref_i),
            .cov_i  (cov_w),
            .ctrl_i (c_w),
            .en_o   (d_en[l]),
            .hit_o  (d_hit[l])
        );

        bp_addr_cmp #(.ADDR_W(ADDR_W)) u_addr (
            .addr_i (bus_addr_i),
            .lo_i   (addr_lo_i),
            .hi_i   (addr_hi_i),
            .ctrl_i (c_w),
            .en_o   (a_en[l]),
            .hit_o  (a_hit[l])
        );

        bp_pc_cmp #(.PC_W(PC_W)) u_pc (
            .pc_i   (pc_i),
            .base_i (pc_base_i),
            .mask_i (pc_mask_i),
            .ctrl_i (c_w),
            .en_o   (p_en[l]),
            .hit_o  (p_hit[l])
        );

        assign lvl_match[l] = (d_en[l] | a_en[l] | p_en[l])
                            & (~d_en[l] | d_hit[l])
                            & (~a_en[l] | a_hit[l])
                            & (~p_en[l] | p_hit[l]);

        // An unarmed level stays quiet
        assert_unarmed_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_valid_i && !d_en[l] && !a_en[l] && !p_en[l]) |=> !trig_o[l]);

        // Both window senses together cover every address
        assert_window_cover_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (c_w.addr_win && c_w.addr_out) |-> a_hit[l]);

        // Full mask with in-region sense always matches
        assert_full_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (c_w.pc_en && !c_w.pc_inv && (&pc_mask_i)) |-> p_hit[l]);

        // No data enable, no data hit, even with inversion
        assert_data_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (c_w[USED_W-1 -: NUM_LANES] == '0) |-> !d_hit[l]);

        // Reserved size drives no lane
        assert_no_lane_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_size_i == SZ_NONE) |-> !d_hit[l]);

        // A trigger follows a valid bus cycle
        assert_trig_after_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
            trig_o[l] |-> $past(bus_valid_i));
    end

    always_comb begin
        st_d      = st_q;
        st_d.trig = bus_valid_i ? lvl_match : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign trig_o = st_q.trig;

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid_i |=> (trig_o == '0));

    // Groups combine by AND: a single enabled group that misses blocks the level
    assert_and_combine_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid_i && a_en[0] && !a_hit[0]) |=> !trig_o[0]);

endmodule

// File: tb/tb_bp_trigger_unit.sv
module tb_bp_trigger_unit;
    import bp_pkg::*;

    localparam int ADDR_W = 32;
    localparam int PC_W   = 32;
    localparam int LEVELS = 2;

    logic                      clk = 1'b0;
    logic                      rst_n;
    logic [SLICE_W*LEVELS-1:0] ctrl_i;
    logic [31:0]               data_ref_i;
    logic [ADDR_W-1:0]         addr_lo_i, addr_hi_i, bus_addr_i;
    logic [PC_W-1:0]           pc_base_i, pc_mask_i, pc_i;
    logic                      bus_valid_i;
    logic [1:0]                bus_size_i;
    logic [31:0]               bus_data_i;
    logic [LEVELS-1:0]         trig_o;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    bp_trigger_unit #(.ADDR_W(ADDR_W), .PC_W(PC_W), .LEVELS(LEVELS)) dut (
        .clk, .rst_n, .ctrl_i, .data_ref_i, .addr_lo_i, .addr_hi_i,
        .pc_base_i, .pc_mask_i, .bus_valid_i, .bus_addr_i, .bus_size_i,
        .bus_data_i, .pc_i, .trig_o
    );

    // Reference model built from the requirement text
    function automatic logic ref_level(input logic [12:0] c);
        logic [3:0] driven;
        logic [3:0] lane_bytes;
        logic       den, dhit, aen, ahit, pen, phit, inwin;
        logic [31:0] diff;
        den = 1'b0; dhit = 1'b0;
        case (bus_size_i)
            2'b00:   driven = 4'b1000 >> bus_addr_i[1:0];
            2'b01:   driven = bus_addr_i[1] ? 4'b0011 : 4'b1100;
            2'b10:   driven = 4'b1111;
            default: driven = 4'b0000;
        endcase
        diff = bus_data_i ^ data_ref_i;
        for (int i = 0; i < 7; i++) begin
            case (i)
                0: lane_bytes = 4'b1000;
                1: lane_bytes = 4'b0100;
                2: lane_bytes = 4'b0010;
                3: lane_bytes = 4'b0001;
                4: lane_bytes = 4'b1100;
                5: lane_bytes = 4'b0011;
                default: lane_bytes = 4'b1111;
            endcase
            if (c[6+i]) begin
                den = 1'b1;
                if ((lane_bytes & ~driven) == 4'b0000) begin
                    logic same;
                    same = 1'b1;
                    for (int b = 0; b < 4; b++)
                        if (lane_bytes[b] && diff[b*8 +: 8] != 8'h00) same = 1'b0;
                    if (same ^ c[5]) dhit = 1'b1;
                end
            end
        end
        inwin = (bus_addr_i >= addr_lo_i) && (bus_addr_i <= addr_hi_i);
        aen   = c[4] | c[3] | c[2];
        ahit  = (c[2] && bus_addr_i == addr_lo_i) || (c[3] && inwin) || (c[4] && !inwin);
        pen   = c[1];
        phit  = ((((pc_i ^ pc_base_i) & ~pc_mask_i) == '0) ? 1'b1 : 1'b0) ^ c[0];
        return bus_valid_i && (den || aen || pen)
               && (!den || dhit) && (!aen || ahit) && (!pen || phit);
    endfunction

    function automatic logic [1:0] ref_trig();
        return {ref_level(ctrl_i[28:16]), ref_level(ctrl_i[12:0])};
    endfunction

    task automatic compare(input string tag, input logic [1:0] exp);
        checks++;
        if (trig_o !== exp) begin
            errors++;
            $display("FAIL %s: trig_o=%b expected=%b", tag, trig_o, exp);
        end
    endtask

    // Inputs already set at a falling edge; sample one full cycle later
    task automatic run(input string tag);
        logic [1:0] exp;
        exp = ref_trig();
        @(posedge clk);
        @(negedge clk);
        compare(tag, exp);
    endtask

    task automatic idle();
        bus_valid_i = 1'b0;
        ctrl_i      = '0;
        bus_size_i  = 2'b10;
        bus_addr_i  = 32'h0000_2000;
        bus_data_i  = data_ref_i;
        pc_i        = pc_base_i;
    endtask

    initial begin
        rst_n       = 1'b0;
        data_ref_i  = 32'hA5C3_3C5A;
        addr_lo_i   = 32'h0000_1000;
        addr_hi_i   = 32'h0000_1010;
        pc_base_i   = 32'h0040_0000;
        pc_mask_i   = 32'h0000_00FF;
        idle();
        ctrl_i      = 32'h1FFF_1FFF;
        bus_valid_i = 1'b1;
        repeat (3) @(negedge clk);
        compare("R1 in reset", 2'b00);
        rst_n = 1'b1;
        idle();
        @(posedge clk);
        @(negedge clk);
        compare("R1 after reset", 2'b00);

        // Data lanes: every lane, invert, access shape and one-bit corruption
        for (int lane = 0; lane < 7; lane++) begin
            for (int di = 0; di < 2; di++) begin
                for (int acc = 0; acc < 7; acc++) begin
                    for (int pat = 0; pat < 5; pat++) begin
                        string tag;
                        tag = (di != 0) ? "R7 inverted lane" :
                              (lane == 6) ? "R4 longword lane" :
                              (lane >= 4) ? "R5 word lane" : "R6 byte lane";
                        ctrl_i      = '0;
                        ctrl_i[6+lane] = 1'b1;
                        ctrl_i[5]   = di[0];
                        bus_valid_i = 1'b1;
                        if (acc < 4) begin
                            bus_size_i = 2'b00; bus_addr_i = 32'h0000_2000 | acc;
                        end else if (acc < 6) begin
                            bus_size_i = 2'b01; bus_addr_i = 32'h0000_2000 | ((acc - 4) * 2);
                        end else begin
                            bus_size_i = 2'b10; bus_addr_i = 32'h0000_2000;
                        end
                        bus_data_i = data_ref_i;
                        if (pat > 0) bus_data_i = data_ref_i ^ (32'h8 << (8 * (pat - 1)));
                        run(tag);
                    end
                end
            end
        end

        // Reserved size with every lane enabled, both senses
        for (int di = 0; di < 2; di++) begin
            ctrl_i = '0; ctrl_i[12:6] = 7'h7F; ctrl_i[5] = di[0];
            bus_valid_i = 1'b1; bus_size_i = 2'b11; bus_data_i = ~data_ref_i;
            run("R11 reserved size");
        end

        // Invert bits alone arm nothing
        idle(); ctrl_i = 32'h0021_0021; bus_valid_i = 1'b1; bus_data_i = ~data_ref_i;
        pc_i = 32'hFFFF_FFFF;
        run("R3 invert only");

        // Address: every enable combination against points around the window
        for (int ea = 0; ea < 8; ea++) begin
            for (int pt = 0; pt < 6; pt++) begin
                logic [31:0] pts [6];
                pts = '{32'h0FFF, 32'h1000, 32'h1001, 32'h100F, 32'h1010, 32'h1011};
                idle();
                ctrl_i[4:2] = ea[2:0];
                bus_valid_i = 1'b1;
                bus_addr_i  = pts[pt];
                run((ea == 0) ? "R3 no enables" : "R8 address");
            end
        end

        // PC: masks, offsets and both senses
        for (int m = 0; m < 3; m++) begin
            for (int o = 0; o < 4; o++) begin
                for (int inv = 0; inv < 2; inv++) begin
                    logic [31:0] offs [4];
                    offs = '{32'h0, 32'h1, 32'h10, 32'h8000_0000};
                    idle();
                    pc_mask_i = (m == 0) ? 32'h0 : (m == 1) ? 32'hF : 32'hFFFF_FFFF;
                    ctrl_i[1] = 1'b1; ctrl_i[0] = inv[0];
                    bus_valid_i = 1'b1;
                    pc_i = pc_base_i ^ offs[o];
                    run("R9 pc region");
                end
            end
        end
        pc_mask_i = 32'h0000_00FF;

        // All three groups at once, each match toggled
        for (int k = 0; k < 8; k++) begin
            idle();
            ctrl_i[12] = 1'b1; ctrl_i[2] = 1'b1; ctrl_i[1] = 1'b1;
            bus_valid_i = 1'b1;
            bus_data_i = k[0] ? data_ref_i : data_ref_i ^ 32'h1;
            bus_addr_i = k[1] ? addr_lo_i  : addr_lo_i + 32'h4;
            pc_i       = k[2] ? pc_base_i  : pc_base_i ^ 32'h100;
            run("R10 all groups");
        end

        // Two levels with separate slices
        for (int k = 0; k < 4; k++) begin
            idle();
            ctrl_i[1]  = 1'b1;            // level 0: PC
            ctrl_i[18] = 1'b1;            // level 1: address equal
            bus_valid_i = 1'b1;
            pc_i       = k[0] ? pc_base_i : pc_base_i ^ 32'h200;
            bus_addr_i = k[1] ? addr_lo_i : addr_hi_i;
            run("R11 two levels");
        end

        // Matching conditions without the valid strobe, then valid after idle
        idle(); ctrl_i = 32'h1000_1000; bus_valid_i = 1'b1;
        run("R2 valid match");
        bus_valid_i = 1'b0;
        run("R2 strobe low");
        bus_valid_i = 1'b1;
        run("R2 strobe back");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule